// File: doc/BRIEF.md
# Four-Channel Power Enable Sequencer

This block is a synchronous controller for four active-high enable lines that bring up downstream supply rails. The channels are called A, B, C and D. It raises them one at a time in the order A, B, C, D and lowers them in the order D, C, B, A. A programmable start delay comes before the first change in either direction. A separate programmable gap governs each neighbouring pair of channels, and the same gap is used going up and going down. All delays are counts of clock cycles, taken from ports.

Sequencing needs two conditions: the supply-valid flag must be high and the sequence request must be high. The integrating level ties the request high when nothing drives it. If the supply-valid flag is seen low in any state, all four enables drop together and the controller goes back to waiting. Two status outputs report progress: `busy` marks a running wait or gap, and `done` marks the fully-on steady state.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `en_out`, `busy` and `done` are all 0. This holds whatever the other inputs do.
- R2: `en_out` bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. The value is always a thermometer code (0, 1, 3, 7 or 15). Apart from a fault, at most one bit changes per clock.
- R3: The controller is idle when it has all enables off and no wait running. When an idle controller first samples `supply_ok` and `seq_req` both high at clock edge t, A rises at edge t + `start_dly` + 1. If `supply_ok` or `seq_req` is sampled low during this wait, the wait is cancelled and A does not rise.
- R4: B rises `gap_ab`+2 cycles after A, C rises `gap_bc`+2 cycles after B, and D rises `gap_cd`+2 cycles after C. A setting of 0 gives 2 cycles.
- R5: With all four on and idle otherwise, suppose `seq_req` is first sampled low at edge t. D then falls at edge t + `start_dly` + 1.
- R6: C falls `gap_cd`+2 cycles after D, B falls `gap_bc`+2 cycles after C, and A falls `gap_ab`+2 cycles after B.
- R7: If `supply_ok` is sampled low at an edge while anything is on or a wait is running, all four enables are 0 after that edge. A later restart waits a full new start delay, counted from the edge that first samples `supply_ok` high again.
- R8: If `seq_req` rises again during the turn-off, the turn-off still runs to its end. A then rises again at edge (A fall edge) + `start_dly` + 2.
- R9: If `seq_req` falls after A has risen but before D has risen, the turn-on still runs to its end. D then falls at edge (D rise edge) + `start_dly` + 2.
- R10: `done` is 1 only while all four enables are on and no turn-off has started. `busy` is 1 exactly while a start wait or an inter-channel gap is running. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Monitored supply inside its valid window |
| seq_req | input | 1 | Request to be on (high) or off (low); tie high when unused |
| start_dly | input | CNT_W | Start delay in cycles, used before A rises and before D falls |
| gap_ab | input | CNT_W | Extra cycles between A and B (both directions) |
| gap_bc | input | CNT_W | Extra cycles between B and C (both directions) |
| gap_cd | input | CNT_W | Extra cycles between C and D (both directions) |
| en_out | output | 4 | Enables, bit 0 = A through bit 3 = D |
| busy | output | 1 | A wait or gap is running |
| done | output | 1 | All four on, steady |

## Verification
A wrong timer load or a wrong gap choice shows up as an enable edge that is early or late by a fixed number of cycles. It appears at the first transition that uses the bad value. A stage index that drifts appears at once as a non-thermometer `en_out`, or as a gap borrowed from the wrong pair. A state that fails to leave idle, full-on or a fault appears on `busy` and `done` in the very next cycle. The bench runs a cycle model next to the design and compares the outputs every cycle, so any divergence is reported at the edge where it first becomes visible.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int CH_NUM   = 4;
    localparam int CH_IDX_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ON_WAIT,
        ST_ON_GAP,
        ST_FULL,
        ST_OFF_WAIT,
        ST_OFF_GAP
    } seq_state_e;

    // Command from the controller to the enable bank
    typedef struct packed {
        logic                clr_all;
        logic                set_one;
        logic                clr_one;
        logic [CH_IDX_W-1:0] idx;
    } en_cmd_t;

    function automatic logic state_is_busy(seq_state_e s);
        return (s == ST_ON_WAIT) || (s == ST_ON_GAP) ||
               (s == ST_OFF_WAIT) || (s == ST_OFF_GAP);
    endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_gap_sel.sv
module pwr_seq_gap_sel
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_GAP = 2,
    parameter int TMR_W   = CNT_W + 2
) (
    input  logic [CH_NUM-2:0][CNT_W-1:0] gaps,
    input  logic [CNT_W-1:0]             start_dly,
    input  logic                         use_start,
    input  logic [CH_IDX_W-1:0]          sel,
    output logic [TMR_W-1:0]             load_val
);
    localparam logic [TMR_W-1:0] GAP_BIAS = TMR_W'(MIN_GAP - 1);

    logic [CNT_W-1:0] gap_pick;

    always_comb begin
        gap_pick = '0;
        for (int k = 0; k < CH_NUM - 1; k++) begin
            if (sel == CH_IDX_W'(k))
                gap_pick = gaps[k];
        end
    end

    always_comb begin
        if (use_start)
            load_val = TMR_W'(start_dly);
        else
            load_val = TMR_W'(gap_pick) + GAP_BIAS;
    end
endmodule

// File: rtl/pwr_seq_en_bank.sv
module pwr_seq_en_bank
    import pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  en_cmd_t           cmd,
    output logic [CH_NUM-1:0] en
);
    for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst || cmd.clr_all)
                en[g] <= 1'b0;
            else if (cmd.set_one && (cmd.idx == CH_IDX_W'(g)))
                en[g] <= 1'b1;
            else if (cmd.clr_one && (cmd.idx == CH_IDX_W'(g)))
                en[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                supply_ok,
    input  logic                seq_req,
    input  logic                expired,
    output logic                load,
    output logic                use_start,
    output logic [CH_IDX_W-1:0] gap_sel,
    output en_cmd_t             cmd,
    output logic                busy,
    output logic                done
);
    localparam logic [CH_IDX_W-1:0] LAST = CH_IDX_W'(CH_NUM - 1);

    seq_state_e          st_q, st_d;
    logic [CH_IDX_W-1:0] stg_q, stg_d;
    logic [CH_IDX_W-1:0] stg_up, stg_dn;

    assign stg_up = stg_q + 1'b1;
    assign stg_dn = stg_q - 1'b1;

    always_comb begin
        st_d      = st_q;
        stg_d     = stg_q;
        load      = 1'b0;
        use_start = 1'b0;
        gap_sel   = '0;
        cmd       = '0;
        if (!supply_ok && (st_q != ST_IDLE)) begin
            cmd.clr_all = 1'b1;
            st_d        = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (supply_ok && seq_req) begin
                        load      = 1'b1;
                        use_start = 1'b1;
                        st_d      = ST_ON_WAIT;
                    end
                end
                ST_ON_WAIT: begin
                    if (!seq_req) begin
                        st_d = ST_IDLE;
                    end else if (expired) begin
                        cmd.set_one = 1'b1;
                        cmd.idx     = '0;
                        stg_d       = '0;
                        load        = 1'b1;
                        gap_sel     = '0;
                        st_d        = ST_ON_GAP;
                    end
                end
                ST_ON_GAP: begin
                    if (expired) begin
                        cmd.set_one = 1'b1;
                        cmd.idx     = stg_up;
                        stg_d       = stg_up;
                        if (stg_up == LAST) begin
                            st_d = ST_FULL;
                        end else begin
                            load    = 1'b1;
                            gap_sel = stg_up;
                        end
                    end
                end
                ST_FULL: begin
                    if (!seq_req) begin
                        load      = 1'b1;
                        use_start = 1'b1;
                        st_d      = ST_OFF_WAIT;
                    end
                end
                ST_OFF_WAIT: begin
                    if (expired) begin
                        cmd.clr_one = 1'b1;
                        cmd.idx     = LAST;
                        stg_d       = LAST;
                        load        = 1'b1;
                        gap_sel     = LAST - 1'b1;
                        st_d        = ST_OFF_GAP;
                    end
                end
                ST_OFF_GAP: begin
                    if (expired) begin
                        cmd.clr_one = 1'b1;
                        cmd.idx     = stg_dn;
                        stg_d       = stg_dn;
                        if (stg_dn == '0) begin
                            st_d = ST_IDLE;
                        end else begin
                            load    = 1'b1;
                            gap_sel = stg_dn - 1'b1;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            stg_q <= '0;
        end else begin
            st_q  <= st_d;
            stg_q <= stg_d;
        end
    end

    assign busy = state_is_busy(st_q);
    assign done = (st_q == ST_FULL);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_GAP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              seq_req,
    input  logic [CNT_W-1:0]  start_dly,
    input  logic [CNT_W-1:0]  gap_ab,
    input  logic [CNT_W-1:0]  gap_bc,
    input  logic [CNT_W-1:0]  gap_cd,
    output logic [CH_NUM-1:0] en_out,
    output logic              busy,
    output logic              done
);
    localparam int TMR_W = CNT_W + 2;

    logic [CH_NUM-2:0][CNT_W-1:0] gaps;
    logic                         load, use_start, expired;
    logic [CH_IDX_W-1:0]          gap_sel;
    logic [TMR_W-1:0]             load_val;
    en_cmd_t                      cmd;

    assign gaps[0] = gap_ab;
    assign gaps[1] = gap_bc;
    assign gaps[2] = gap_cd;

    pwr_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .seq_req   (seq_req),
        .expired   (expired),
        .load      (load),
        .use_start (use_start),
        .gap_sel   (gap_sel),
        .cmd       (cmd),
        .busy      (busy),
        .done      (done)
    );

    pwr_seq_gap_sel #(
        .CNT_W   (CNT_W),
        .MIN_GAP (MIN_GAP),
        .TMR_W   (TMR_W)
    ) u_gap_sel (
        .gaps      (gaps),
        .start_dly (start_dly),
        .use_start (use_start),
        .sel       (gap_sel),
        .load_val  (load_val)
    );

    pwr_seq_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    pwr_seq_en_bank u_en_bank (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .en  (en_out)
    );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         supply_ok,
    input logic [N-1:0] en_out,
    input logic         busy,
    input logic         done
);
    localparam logic [N-1:0] ONE = N'(1);

    assert_fault_drop_R7: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (en_out == '0));

    assert_thermo_R2: assert property (@(posedge clk) disable iff (rst)
        ((en_out & (en_out + ONE)) == '0));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        supply_ok |=> ($countones(en_out ^ $past(en_out)) <= 1));

    // Covers the minimum spacing of both directions (R6 as well)
    assert_min_gap_R4: assert property (@(posedge clk) disable iff (rst)
        ((en_out != $past(en_out)) && supply_ok) |=> $stable(en_out));

    assert_done_full_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> ((en_out == '1) && !busy));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.N(pwr_seq_pkg::CH_NUM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .en_out    (en_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int WD_LIMIT   = 150000;

    logic             clk = 1'b0;
    logic             rst;
    logic             supply_ok, seq_req;
    logic [CNT_W-1:0] start_dly, gap_ab, gap_bc, gap_cd;
    logic [3:0]       en_out;
    logic             busy, done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    pwr_seq_ctrl #(.CNT_W(CNT_W), .MIN_GAP(2)) dut_i (
        .clk (clk), .rst (rst), .supply_ok (supply_ok), .seq_req (seq_req),
        .start_dly (start_dly), .gap_ab (gap_ab), .gap_bc (gap_bc),
        .gap_cd (gap_cd), .en_out (en_out), .busy (busy), .done (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: mode, remaining wait, number of channels on
    int mmode = 0;   // 0 idle,1 on-wait,2 on-gap,3 full,4 off-wait,5 off-gap
    int mrem  = 0;
    int mlvl  = 0;

    function automatic int gap_of(int k);
        case (k)
            0: return int'(gap_ab);
            1: return int'(gap_bc);
            default: return int'(gap_cd);
        endcase
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            mmode = 0; mlvl = 0; mrem = 0;
        end else if (!supply_ok && mmode != 0) begin
            mmode = 0; mlvl = 0;
        end else begin
            case (mmode)
                0: if (supply_ok && seq_req) begin mmode = 1; mrem = int'(start_dly); end
                1: if (!seq_req) mmode = 0;
                   else if (mrem == 0) begin mlvl = 1; mmode = 2; mrem = gap_of(0) + 1; end
                   else mrem--;
                2: if (mrem == 0) begin
                       mlvl++;
                       if (mlvl == 4) mmode = 3; else mrem = gap_of(mlvl - 1) + 1;
                   end else mrem--;
                3: if (!seq_req) begin mmode = 4; mrem = int'(start_dly); end
                4: if (mrem == 0) begin mlvl = 3; mmode = 5; mrem = gap_of(2) + 1; end
                   else mrem--;
                5: if (mrem == 0) begin
                       mlvl--;
                       if (mlvl == 0) mmode = 0; else mrem = gap_of(mlvl - 1) + 1;
                   end else mrem--;
                default: mmode = 0;
            endcase
        end
        if (cyc == WD_LIMIT) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Per-cycle comparison and edge time recording
    logic [3:0] prev_en = 4'd0;
    int rise_c[4];
    int fall_c[4];

    always @(negedge clk) begin
        int exp_en;
        exp_en = (1 << mlvl) - 1;
        check(en_out == 4'(exp_en), "R2 model en_out", int'(en_out), exp_en);
        check(busy == (mmode == 1 || mmode == 2 || mmode == 4 || mmode == 5),
              "R10 model busy", int'(busy), 0);
        check(done == (mmode == 3), "R10 model done", int'(done), int'(mmode == 3));
        for (int k = 0; k < 4; k++) begin
            if (en_out[k] && !prev_en[k]) rise_c[k] = cyc;
            if (!en_out[k] && prev_en[k]) fall_c[k] = cyc;
        end
        prev_en = en_out;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin step(); n++; end
        check(done, "R10 reach full-on", int'(done), 1);
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((en_out != 4'd0 || busy) && n < 2000) begin step(); n++; end
        check(en_out == 4'd0, "R6 reach all-off", int'(en_out), 0);
    endtask

    task automatic wait_bit(input int k);
        int n = 0;
        while (!en_out[k] && n < 2000) begin step(); n++; end
        check(en_out[k], "R2 enable rise", int'(en_out[k]), 1);
    endtask

    int t0, t1, tr, fa, r3;
    localparam int S = 5;

    initial begin
        rst = 1'b1; supply_ok = 1'b1; seq_req = 1'b1;
        start_dly = CNT_W'(S); gap_ab = 16'd3; gap_bc = 16'd0; gap_cd = 16'd7;
        repeat (4) step();
        check(en_out == 4'd0, "R1 reset en_out", int'(en_out), 0);
        check(!busy && !done, "R1 reset status", int'({busy, done}), 0);
        rst = 1'b0; supply_ok = 1'b0;
        step();
        check(en_out == 4'd0 && !busy, "R1 idle after reset", int'(en_out), 0);
        repeat (2) step();

        // Normal turn-on
        supply_ok = 1'b1; t0 = cyc + 1;
        wait_done();
        check(rise_c[0] == t0 + S + 1, "R3 start delay", rise_c[0] - t0, S + 1);
        check(rise_c[1] - rise_c[0] == 5, "R4 gap A-B", rise_c[1] - rise_c[0], 5);
        check(rise_c[2] - rise_c[1] == 2, "R4 zero gap B-C", rise_c[2] - rise_c[1], 2);
        check(rise_c[3] - rise_c[2] == 9, "R4 gap C-D", rise_c[3] - rise_c[2], 9);
        check(done && !busy && en_out == 4'hF, "R10 full-on status", int'(en_out), 15);

        // Normal turn-off
        seq_req = 1'b0; t1 = cyc + 1;
        wait_idle();
        check(fall_c[3] == t1 + S + 1, "R5 off start delay", fall_c[3] - t1, S + 1);
        check(fall_c[3] - fall_c[2] == -9, "R6 gap D-C", fall_c[2] - fall_c[3], 9);
        check(fall_c[1] - fall_c[2] == 2, "R6 gap C-B", fall_c[1] - fall_c[2], 2);
        check(fall_c[0] - fall_c[1] == 5, "R6 gap B-A", fall_c[0] - fall_c[1], 5);
        check(!busy && !done, "R10 idle status", int'({busy, done}), 0);

        // Fault while fully on
        seq_req = 1'b1;
        wait_done();
        supply_ok = 1'b0;
        step();
        check(en_out == 4'd0, "R7 fault clears all", int'(en_out), 0);
        check(!done && !busy, "R7 fault idle", int'({busy, done}), 0);
        repeat (2) step();
        supply_ok = 1'b1; tr = cyc + 1;
        wait_done();
        check(rise_c[0] == tr + S + 1, "R7 restart delay", rise_c[0] - tr, S + 1);

        // Fault during start wait
        seq_req = 1'b0;
        wait_idle();
        supply_ok = 1'b0; seq_req = 1'b1;
        repeat (2) step();
        supply_ok = 1'b1;
        repeat (2) step();
        supply_ok = 1'b0;
        step();
        supply_ok = 1'b1; t0 = cyc + 1;
        wait_done();
        check(rise_c[0] == t0 + S + 1, "R3 wait cancelled by supply", rise_c[0] - t0, S + 1);

        // Request withdrawn during start wait
        seq_req = 1'b0;
        wait_idle();
        seq_req = 1'b1;
        repeat (2) step();
        seq_req = 1'b0;
        repeat (S + 6) step();
        check(en_out == 4'd0 && !busy, "R3 wait cancelled by request", int'(en_out), 0);

        // Request reasserted during turn-off
        seq_req = 1'b1;
        wait_done();
        seq_req = 1'b0;
        while (en_out[3]) step();
        seq_req = 1'b1;
        wait_idle();
        fa = fall_c[0];
        check(fall_c[0] - fall_c[1] == 5, "R8 off completes", fall_c[0] - fall_c[1], 5);
        wait_bit(0);
        check(rise_c[0] == fa + S + 2, "R8 fresh turn-on", rise_c[0] - fa, S + 2);
        wait_done();

        // Request withdrawn during turn-on, zero start delay
        seq_req = 1'b0;
        wait_idle();
        start_dly = '0;
        seq_req = 1'b1; t0 = cyc + 1;
        wait_bit(0);
        check(rise_c[0] == t0 + 1, "R3 zero start delay", rise_c[0] - t0, 1);
        step();
        seq_req = 1'b0;
        wait_bit(3);
        r3 = rise_c[3];
        wait_idle();
        check(fall_c[3] == r3 + 2, "R9 on completes then off", fall_c[3] - r3, 2);

        repeat (3) step();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule